// File: doc/BRIEF.md
# Per-Hart Software Interrupt Register File

This block holds one software-interrupt pending bit for each hart in a multi-hart system. Software raises an inter-processor interrupt by writing a 1 into the word that belongs to the target hart and withdraws it by writing a 0. Each stored bit drives its own level interrupt line to its hart. The bit is cleared only by a later bus write.

Register access uses a small 32-bit request/response bus. A request is a single-cycle `req_valid` pulse with write flag, 16-bit byte offset and write data. The block has no back-pressure: it takes a request in every cycle that `req_valid` is high. Exactly one cycle later it returns a response pulse with read data and an error flag.

A parameter selects one of two variants. The machine variant returns the stored bit on reads. The supervisor variant always reads zero, so it is in effect write-only. The hart count is also a parameter (default 4).

Top module: `swi_regfile`

## Requirements
- R1: Every cycle with `req_valid` high produces `rsp_valid` high in the following cycle. A cycle with `req_valid` low produces `rsp_valid` low in the following cycle.
- R2: Hart h owns the 32-bit word at byte offset 4*h. The hart index is `req_off[13:2]` and `req_off[1:0]` is ignored.
- R3: A write inside the window to an existing hart stores only bit 0 of `req_wdata`. Bits 31:1 are discarded.
- R4: In the machine variant (`VARIANT`=0), a read of an existing hart returns its stored bit in `rsp_rdata[0]`, with bits 31:1 zero.
- R5: In the supervisor variant (`VARIANT`=1), every read returns `rsp_rdata` = 0, whatever is stored.
- R6: An offset at or above 0x4000 gives `rsp_err` = 1 and `rsp_rdata` = 0. A write to such an offset changes no pending bit.
- R7: An offset below 0x4000 whose hart index is at or above `NUM_HARTS` reads as zero, ignores writes and gives `rsp_err` = 0.
- R8: `irq[h]` is high exactly when hart h's stored bit is 1. It takes a written value on the clock edge that accepts the write, and no other bit of `irq` changes.
- R9: Reset (`rst_n` low, asynchronous) clears all pending bits, so `irq` is 0 and `rsp_valid` is 0.
- R10: Every write response carries `rsp_rdata` = 0. `rsp_err` is 0 for any offset below 0x4000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle (always accepted) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_off | input | 16 | Byte offset into the register window |
| req_wdata | input | 32 | Write data; only bit 0 is used |
| rsp_valid | output | 1 | Response pulse, one cycle after the request |
| rsp_rdata | output | 32 | Read data of the response |
| rsp_err | output | 1 | Offset outside the window |
| irq | output | NUM_HARTS | Level software interrupt, one per hart |

## Verification
One machine instance and one supervisor instance receive the same request stream. This shows that storage and interrupt lines are identical in both variants and that only read data differs.

Directed writes use data whose bit 0 disagrees with the upper bits, which separates real bit-0 storage from any-bit-set logic. Offsets with nonzero low two bits show that those bits are ignored.

Offsets just past the last hart, and at and beyond the window edge, separate the silent ignore case from the error case. Random mixes of reads and writes over all three regions then follow the pending state against a bench model.

// File: rtl/swi_pkg.sv
package swi_pkg;
  localparam int unsigned SWI_WIN_LOG2  = 14;
  localparam int unsigned SWI_WIN_BYTES = 1 << SWI_WIN_LOG2;
  localparam int unsigned SWI_STRIDE_LOG2 = 2;
  localparam int unsigned SWI_IDX_W = SWI_WIN_LOG2 - SWI_STRIDE_LOG2;
  localparam int unsigned SWI_MAX_HARTS = 1 << SWI_IDX_W;

  typedef enum logic {
    SWI_MACHINE = 1'b0,
    SWI_SUPER   = 1'b1
  } swi_variant_e;

  typedef struct packed {
    logic                 in_win;
    logic                 hit;
    logic [SWI_IDX_W-1:0] idx;
  } swi_dec_t;
endpackage

// File: rtl/swi_decode.sv
module swi_decode
  import swi_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned OFF_W     = 16
) (
  input  logic [OFF_W-1:0] off,
  output swi_dec_t         dec
);
  logic [31:0] off_ext;

  always_comb begin
    off_ext    = 32'(off);
    dec.in_win = off_ext < SWI_WIN_BYTES;
    dec.idx    = off_ext[SWI_WIN_LOG2-1:SWI_STRIDE_LOG2];
    dec.hit    = dec.in_win && (32'(dec.idx) < NUM_HARTS);
  end
endmodule

// File: rtl/swi_bank.sv
module swi_bank
  import swi_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SWI_IDX_W-1:0] wr_idx,
  input  logic                 wr_bit,
  input  logic [SWI_IDX_W-1:0] rd_idx,
  output logic                 rd_bit,
  output logic [NUM_HARTS-1:0] pend
);
  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pend[h] <= 1'b0;
      else if (wr_en && (wr_idx == SWI_IDX_W'(h)))
        pend[h] <= wr_bit;
    end
  end

  always_comb begin
    rd_bit = 1'b0;
    for (int h = 0; h < NUM_HARTS; h++)
      if (rd_idx == SWI_IDX_W'(h)) rd_bit = pend[h];
  end
endmodule

// File: rtl/swi_resp.sv
module swi_resp
  import swi_pkg::*;
#(
  parameter swi_variant_e VARIANT = SWI_MACHINE,
  parameter int unsigned  DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  swi_dec_t          dec,
  input  logic              rd_bit,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  logic rd_visible;

  always_comb begin
    if (VARIANT == SWI_SUPER)
      rd_visible = 1'b0;
    else
      rd_visible = req_valid && !req_write && dec.hit && rd_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !dec.in_win;
      rsp_rdata <= {{(DATA_W-1){1'b0}}, rd_visible};
    end
  end
endmodule

// File: rtl/swi_regfile.sv
module swi_regfile
  import swi_pkg::*;
#(
  parameter int unsigned  NUM_HARTS = 4,
  parameter swi_variant_e VARIANT   = SWI_MACHINE,
  parameter int unsigned  OFF_W     = 16,
  parameter int unsigned  DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [OFF_W-1:0]     req_off,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 rsp_err,
  output logic [NUM_HARTS-1:0] irq
);
  swi_dec_t dec;
  logic     rd_bit;
  logic     wr_en;

  assign wr_en = req_valid && req_write && dec.hit;

  swi_decode #(.NUM_HARTS(NUM_HARTS), .OFF_W(OFF_W)) u_dec (
    .off (req_off),
    .dec (dec)
  );

  swi_bank #(.NUM_HARTS(NUM_HARTS)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (dec.idx),
    .wr_bit (req_wdata[0]),
    .rd_idx (dec.idx),
    .rd_bit (rd_bit),
    .pend   (irq)
  );

  swi_resp #(.VARIANT(VARIANT), .DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .dec       (dec),
    .rd_bit    (rd_bit),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );
endmodule

// File: rtl/swi_regfile_chk.sv
module swi_regfile_chk
  import swi_pkg::*;
#(
  parameter int unsigned  NUM_HARTS = 4,
  parameter swi_variant_e VARIANT   = SWI_MACHINE,
  parameter int unsigned  OFF_W     = 16,
  parameter int unsigned  DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_write,
  input logic [OFF_W-1:0]     req_off,
  input logic [DATA_W-1:0]    req_wdata,
  input logic                 rsp_valid,
  input logic [DATA_W-1:0]    rsp_rdata,
  input logic                 rsp_err,
  input logic [NUM_HARTS-1:0] irq
);
  logic                 out_win;
  logic                 hit;
  logic [SWI_IDX_W-1:0] h_idx;

  assign out_win = 32'(req_off) >= SWI_WIN_BYTES;
  assign h_idx   = req_off[SWI_WIN_LOG2-1:SWI_STRIDE_LOG2];
  assign hit     = !out_win && (32'(h_idx) < NUM_HARTS);

  // R1
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R1
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R4
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata[DATA_W-1:1] == '0));
  // R5
  super_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && VARIANT == SWI_SUPER) |-> (rsp_rdata == '0));
  // R6
  win_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && out_win) |=> (rsp_err && rsp_rdata == '0));
  // R10
  in_win_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !out_win) |=> !rsp_err);
  // R10
  wr_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> (rsp_rdata == '0));
  // R6 R7
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && hit) |=> $stable(irq));
  // R3 R8
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && hit) |=>
      (irq[$past(h_idx)] == $past(req_wdata[0])));
  // R4
  rd_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && hit && VARIANT == SWI_MACHINE) |=>
      (rsp_rdata[0] == $past(irq[h_idx])));
endmodule

bind swi_regfile swi_regfile_chk #(
  .NUM_HARTS(NUM_HARTS), .VARIANT(VARIANT), .OFF_W(OFF_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_off(req_off), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .irq(irq)
);

// File: tb/swi_regfile_tb.sv
module swi_regfile_tb;
  import swi_pkg::*;
  localparam int unsigned NH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [15:0] req_off = '0;
  logic [31:0] req_wdata = '0;
  logic rv_m, re_m, rv_s, re_s;
  logic [31:0] rd_m, rd_s;
  logic [NH-1:0] irq_m, irq_s;

  logic [NH-1:0] model = '0;
  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #2.5ns clk = ~clk;

  swi_regfile #(.NUM_HARTS(NH), .VARIANT(SWI_MACHINE)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_off(req_off), .req_wdata(req_wdata), .rsp_valid(rv_m),
    .rsp_rdata(rd_m), .rsp_err(re_m), .irq(irq_m));

  swi_regfile #(.NUM_HARTS(NH), .VARIANT(SWI_SUPER)) u_dut_sup (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_off(req_off), .req_wdata(req_wdata), .rsp_valid(rv_s),
    .rsp_rdata(rd_s), .rsp_err(re_s), .irq(irq_s));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic exp_err(input logic [15:0] off);
    return off >= 16'h4000;
  endfunction

  function automatic logic exp_hit(input logic [15:0] off);
    return !exp_err(off) && (int'(off >> 2) < NH);
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // Called at a negedge: drive, let one posedge pass, check at the next negedge.
  task automatic xfer(input logic w, input logic [15:0] off, input logic [31:0] d);
    logic [31:0] er;
    logic ee;
    int h;
    req_valid = 1'b1; req_write = w; req_off = off; req_wdata = d;
    ee = exp_err(off);
    h  = int'(off >> 2);
    er = '0;
    if (!w && exp_hit(off)) er = {31'b0, model[h]};
    if (w && exp_hit(off)) model[h] = d[0];
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 rsp_valid machine", 32'(rv_m), 32'd1);
    chk("R1 rsp_valid supervisor", 32'(rv_s), 32'd1);
    chk(ee ? "R6 err flag" : "R10 err flag", 32'(re_m), 32'(ee));
    chk("R6 R10 err flag supervisor", 32'(re_s), 32'(ee));
    chk(w ? "R10 write rdata" : "R4 R7 read rdata", rd_m, er);
    chk("R5 supervisor rdata", rd_s, 32'd0);
    chk("R8 irq machine", 32'(irq_m), 32'(model));
    chk("R8 irq supervisor", 32'(irq_s), 32'(model));
  endtask

  initial begin
    #(5ns * 100000);
    vectors++; miscompares++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    chk("R9 irq in reset", 32'(irq_m), 32'd0);
    chk("R9 rsp_valid in reset", 32'(rv_m), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 irq after reset", 32'(irq_m | irq_s), 32'd0);

    // R3: only bit 0 counts
    xfer(1'b1, 16'h0000, 32'hFFFF_FFFE);
    xfer(1'b1, 16'h0000, 32'h0000_0001);
    xfer(1'b0, 16'h0000, 32'h0);                 // R4 reads 1
    xfer(1'b1, 16'h0008, 32'h8000_0003);          // R3 hart 2
    // R2: low offset bits ignored
    xfer(1'b1, 16'h000F, 32'h1);
    xfer(1'b0, 16'h000C, 32'h0);
    xfer(1'b0, 16'h0006, 32'h0);
    // R7: past last hart
    xfer(1'b1, 16'h0010, 32'h1);
    xfer(1'b0, 16'h0010, 32'h0);
    xfer(1'b1, 16'h3FFC, 32'h1);
    // R6: window edge and beyond
    xfer(1'b1, 16'h4000, 32'h0);
    xfer(1'b0, 16'h4000, 32'h0);
    xfer(1'b1, 16'hFFFC, 32'h0);
    // R8: clear one hart, others stay
    xfer(1'b1, 16'h0004, 32'hFFFF_FFFF);
    xfer(1'b1, 16'h0000, 32'h0);
    // R1: idle cycle gives no response
    @(negedge clk);
    chk("R1 idle no response", 32'(rv_m), 32'd0);

    for (int i = 0; i < 400; i++) begin
      logic [15:0] off;
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel < 7)      off = 16'($urandom_range(0, 4 * NH - 1));
      else if (sel < 9) off = 16'($urandom_range(4 * NH, 16'h3FFF));
      else              off = 16'($urandom_range(16'h4000, 16'hFFFF));
      xfer(1'($urandom), off, $urandom);
      if ($urandom_range(0, 3) == 0) begin
        @(negedge clk);
        chk("R1 idle no response", 32'(rv_m), 32'd0);
      end
    end
    finish_run();
  end
endmodule